// File: doc/BRIEF.md
# Virtual Interrupt Interface Control Registers

This block is the control register file of a virtual interrupt CPU interface. It holds one 32-bit control word and two 3-bit binary point registers, one for each interrupt group. It is reached through a single synchronous access port with an address, a write flag, write data and registered read data. The capability fields of the control word come from elaboration parameters and cannot be changed by software. The two writable mode bits are driven out of the block, so that the neighbouring end-of-interrupt and preemption logic can follow them.

The block has two modes that change how it behaves. When the common binary point bit is set, group 0's binary point governs preemption for both groups. In that mode a read of the group-1 register returns the group-0 value plus one, saturated at 7, and writes to the group-1 register are discarded. When the EOI split bit is set, end-of-interrupt only drops priority, and deactivation needs a separate access to the deactivate address. An access to that address while the split bit is clear is flagged as an error.

Top module: `vintf_ctl_regs`

## Requirements
- R1: Reset clears both mode outputs, both binary point registers, the read data and the error flag.
- R2: A read of the control word (address 0) returns zero in bits 31:20, 17:16 and 7:2.
- R3: Control word capability fields come from parameters and ignore writes: bit 19 extended ID range, bit 18 range selector, bit 15 affinity-3 valid, bit 14 local system-error support, bits 13:11 ID width code (000 is 16 bits, 001 is 24 bits), and bits 10:8 the implemented priority bit count minus one, with 5 to 8 bits allowed.
- R4: Control bit 1 (EOI split) is writable, and its stored value drives `eoi_split` from the edge of the write onward.
- R5: Control bit 0 (common binary point) is writable, and its stored value drives `bp_common`. The mode outputs change only on a control word write.
- R6: The group-0 binary point (address 1) stores write data bits 2:0 and reads back with bits 31:3 zero.
- R7: While `bp_common` is 0, the group-1 binary point (address 2) is written and read like group 0.
- R8: While `bp_common` is 1, a read of address 2 returns the group-0 value plus one, saturated at 7.
- R9: While `bp_common` is 1, writes to address 2 are dropped, and the stored group-1 value is seen again once the bit is cleared.
- R10: Read data appears on the edge on which a read is sampled, and it holds unchanged on every cycle without a read.
- R11: An access to the deactivate address (3) while `eoi_split` is 0 raises `acc_err` for exactly one cycle and changes no state. With `eoi_split` at 1 there is no error, and reads of address 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, sampled on the rising edge |
| acc_write | input | 1 | 1 means write, 0 means read |
| acc_addr | input | 2 | 0 control, 1 group-0 BP, 2 group-1 BP, 3 deactivate |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| acc_err | output | 1 | One-cycle flag for a deactivate access in the wrong mode |
| eoi_split | output | 1 | EOI performs priority drop only |
| bp_common | output | 1 | Group-0 binary point governs both groups |

## Verification
The assertions assume that `acc_valid`, `acc_write` and `acc_addr` are known, driven values at every sampled edge after reset, with at most one access per cycle. They also assume that the inputs are held at zero while reset is asserted, because some properties look one cycle back across the reset release. The bench drives every input on the falling edge, holds the strobe low during reset and between directed steps, and never leaves an address or write flag undriven while the strobe is high.

// File: rtl/vintf_pkg.sv
package vintf_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int BP_W   = 3;
    localparam int GROUPS = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL  = 2'd0,
        ADR_BP0   = 2'd1,
        ADR_BP1   = 2'd2,
        ADR_DEACT = 2'd3
    } vintf_addr_e;

    typedef struct packed {
        logic eoi_split;
        logic bp_common;
    } vintf_mode_t;

    function automatic logic [BP_W-1:0] bp_sat_inc(input logic [BP_W-1:0] v);
        return (v == {BP_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/vintf_cap_word.sv
module vintf_cap_word
    import vintf_pkg::*;
#(
    parameter bit         EXT_RANGE   = 1'b1,
    parameter bit         RANGE_SEL   = 1'b0,
    parameter bit         AFF3_VALID  = 1'b1,
    parameter bit         SEI_SUPPORT = 1'b0,
    parameter logic [2:0] ID_CODE     = 3'b001,
    parameter int         PRI_BITS    = 5
) (
    output logic [DATA_W-1:0] cap_word
);
    localparam logic [2:0] PRI_FIELD = 3'(PRI_BITS - 1);

    if (PRI_BITS < 5 || PRI_BITS > 8) begin : g_bad_pri
        $error("PRI_BITS must lie between 5 and 8");
    end

    always_comb begin
        cap_word        = '0;
        cap_word[19]    = EXT_RANGE;
        cap_word[18]    = RANGE_SEL;
        cap_word[15]    = AFF3_VALID;
        cap_word[14]    = SEI_SUPPORT;
        cap_word[13:11] = ID_CODE;
        cap_word[10:8]  = PRI_FIELD;
    end
endmodule

// File: rtl/vintf_bp_bank.sv
module vintf_bp_bank
    import vintf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [GROUPS-1:0] wr_en,
    input  logic [BP_W-1:0] wdata,
    input  logic            bp_common,
    output logic [BP_W-1:0] bp0_view,
    output logic [BP_W-1:0] bp1_view
);
    logic [GROUPS-1:0][BP_W-1:0] bp_d, bp_q;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        // group 1 stops accepting writes while it aliases group 0
        localparam bit ALIASED = (g != 0);
        always_comb begin
            bp_d[g] = bp_q[g];
            if (wr_en[g] && !(ALIASED && bp_common)) begin
                bp_d[g] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_q <= '0;
        end else begin
            bp_q <= bp_d;
        end
    end

    assign bp0_view = bp_q[0];
    assign bp1_view = bp_common ? bp_sat_inc(bp_q[0]) : bp_q[1];
endmodule

// File: rtl/vintf_ctl_regs.sv
module vintf_ctl_regs
    import vintf_pkg::*;
#(
    parameter bit         EXT_RANGE   = 1'b1,
    parameter bit         RANGE_SEL   = 1'b0,
    parameter bit         AFF3_VALID  = 1'b1,
    parameter bit         SEI_SUPPORT = 1'b0,
    parameter logic [2:0] ID_CODE     = 3'b001,
    parameter int         PRI_BITS    = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [1:0]  acc_addr,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    output logic        acc_err,
    output logic        eoi_split,
    output logic        bp_common
);
    typedef struct packed {
        vintf_mode_t       mode;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } ctl_state_t;

    ctl_state_t          st_d, st_q;
    logic [DATA_W-1:0]   cap_word;
    logic [BP_W-1:0]     bp0_view, bp1_view;
    logic [GROUPS-1:0]   bp_wr;
    vintf_addr_e         sel;

    vintf_cap_word #(
        .EXT_RANGE  (EXT_RANGE),
        .RANGE_SEL  (RANGE_SEL),
        .AFF3_VALID (AFF3_VALID),
        .SEI_SUPPORT(SEI_SUPPORT),
        .ID_CODE    (ID_CODE),
        .PRI_BITS   (PRI_BITS)
    ) u_cap (
        .cap_word(cap_word)
    );

    assign sel      = vintf_addr_e'(acc_addr);
    assign bp_wr[0] = acc_valid && acc_write && (sel == ADR_BP0);
    assign bp_wr[1] = acc_valid && acc_write && (sel == ADR_BP1);

    vintf_bp_bank u_bp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bp_wr),
        .wdata    (acc_wdata[BP_W-1:0]),
        .bp_common(st_q.mode.bp_common),
        .bp0_view (bp0_view),
        .bp1_view (bp1_view)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (acc_valid) begin
            unique case (sel)
                ADR_CTRL: begin
                    if (acc_write) begin
                        st_d.mode.eoi_split = acc_wdata[1];
                        st_d.mode.bp_common = acc_wdata[0];
                    end else begin
                        st_d.rdata = cap_word |
                            {{(DATA_W-2){1'b0}}, st_q.mode.eoi_split, st_q.mode.bp_common};
                    end
                end
                ADR_BP0: begin
                    if (!acc_write) st_d.rdata = {{(DATA_W-BP_W){1'b0}}, bp0_view};
                end
                ADR_BP1: begin
                    if (!acc_write) st_d.rdata = {{(DATA_W-BP_W){1'b0}}, bp1_view};
                end
                ADR_DEACT: begin
                    st_d.err = !st_q.mode.eoi_split;
                    if (!acc_write) st_d.rdata = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_rdata = st_q.rdata;
    assign acc_err   = st_q.err;
    assign eoi_split = st_q.mode.eoi_split;
    assign bp_common = st_q.mode.bp_common;
endmodule

// File: rtl/vintf_ctl_regs_chk.sv
module vintf_ctl_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [1:0]  acc_addr,
    input logic [31:0] acc_wdata,
    input logic [31:0] acc_rdata,
    input logic        acc_err,
    input logic        eoi_split,
    input logic        bp_common
);
    logic ctrl_wr, ctrl_rd, bp1_rd, any_rd;
    assign ctrl_wr = acc_valid && acc_write && (acc_addr == 2'd0);
    assign ctrl_rd = acc_valid && !acc_write && (acc_addr == 2'd0);
    assign bp1_rd  = acc_valid && !acc_write && (acc_addr == 2'd2);
    assign any_rd  = acc_valid && !acc_write;

    assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(acc_valid && acc_addr == 2'd3 && !eoi_split));

    assert_mode_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ({eoi_split, bp_common} == $past(acc_wdata[1:0])));

    assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable({eoi_split, bp_common}));

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |=> (acc_rdata[31:20] == 12'h0 && acc_rdata[17:16] == 2'b00
                     && acc_rdata[7:2] == 6'h0));

    assert_alias_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bp1_rd && bp_common) |=> (acc_rdata[2:0] != 3'd0 && acc_rdata[31:3] == '0));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_rd |=> $stable(acc_rdata));
endmodule

bind vintf_ctl_regs vintf_ctl_regs_chk u_chk (.*);

// File: tb/sim_vintf_ctl_regs.sv
`timescale 1ns/1ps
module sim_vintf_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_addr = 2'd0;
    logic [31:0] acc_wdata = 32'h0;
    logic [31:0] acc_rdata;
    logic        acc_err, eoi_split, bp_common;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    vintf_ctl_regs u0 (.*);

    // expected capability word for the default parameters (R3)
    localparam logic [31:0] CAPS = (32'h1 << 19) | (32'h1 << 15) | (32'h1 << 11) | (32'h4 << 8);

    typedef struct packed {
        logic        we;
        logic [1:0]  addr;
        logic [31:0] wdata;
        logic        chk_rd;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic [1:0]  exp_mode;   // {eoi_split, bp_common}
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 32'h0,        1'b1, CAPS,          1'b0, 2'b00},
        '{1'b1, 2'd2, 32'h3,        1'b0, 32'h0,         1'b0, 2'b00},
        '{1'b0, 2'd2, 32'h0,        1'b1, 32'h3,         1'b0, 2'b00},
        '{1'b1, 2'd0, 32'hFFFFFFFF, 1'b0, 32'h0,         1'b0, 2'b11},
        '{1'b0, 2'd0, 32'h0,        1'b1, CAPS | 32'h3,  1'b0, 2'b11},
        '{1'b1, 2'd1, 32'h5,        1'b0, 32'h0,         1'b0, 2'b11},
        '{1'b0, 2'd1, 32'h0,        1'b1, 32'h5,         1'b0, 2'b11},
        '{1'b0, 2'd2, 32'h0,        1'b1, 32'h6,         1'b0, 2'b11},
        '{1'b1, 2'd2, 32'h2,        1'b0, 32'h0,         1'b0, 2'b11},
        '{1'b1, 2'd1, 32'h7,        1'b0, 32'h0,         1'b0, 2'b11},
        '{1'b0, 2'd2, 32'h0,        1'b1, 32'h7,         1'b0, 2'b11},
        '{1'b1, 2'd0, 32'h0,        1'b0, 32'h0,         1'b0, 2'b00},
        '{1'b0, 2'd2, 32'h0,        1'b1, 32'h3,         1'b0, 2'b00},
        '{1'b0, 2'd3, 32'h0,        1'b0, 32'h0,         1'b1, 2'b00},
        '{1'b1, 2'd0, 32'h2,        1'b0, 32'h0,         1'b0, 2'b10},
        '{1'b0, 2'd3, 32'h0,        1'b1, 32'h0,         1'b0, 2'b10},
        '{1'b1, 2'd1, 32'hFFFFFFFA, 1'b0, 32'h0,         1'b0, 2'b10},
        '{1'b0, 2'd1, 32'h0,        1'b1, 32'h2,         1'b0, 2'b10}
    };

    function automatic string vec_req(input int i);
        case (i)
            0:       return "R2/R3";
            1, 2:    return "R7";
            3:       return "R4/R5";
            4:       return "R3";
            5, 6:    return "R6";
            7, 10:   return "R8";
            8, 9:    return "R9";
            11, 12:  return "R9";
            13, 15:  return "R11";
            14:      return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = we;
        acc_addr  = a;
        acc_wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 rdata", acc_rdata, 32'h0);
        check("R1 err", {31'h0, acc_err}, 32'h0);
        check("R1 modes", {30'h0, eoi_split, bp_common}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].we, VECS[i].addr, VECS[i].wdata);
            if (VECS[i].chk_rd) check(vec_req(i), acc_rdata, VECS[i].exp_rd);
            check({vec_req(i), " err"}, {31'h0, acc_err}, {31'h0, VECS[i].exp_err});
            check({vec_req(i), " mode"}, {30'h0, eoi_split, bp_common}, {30'h0, VECS[i].exp_mode});
        end

        // R10: read data holds across idle cycles
        access(1'b0, 2'd0, 32'h0);
        check("R10 read", acc_rdata, CAPS | 32'h2);
        idle();
        idle();
        check("R10 hold", acc_rdata, CAPS | 32'h2);

        // R11: deactivate write in combined mode flags once, changes nothing
        access(1'b1, 2'd0, 32'h0);
        access(1'b1, 2'd3, 32'h7);
        check("R11 err", {31'h0, acc_err}, 32'h1);
        idle();
        check("R11 pulse", {31'h0, acc_err}, 32'h0);
        check("R11 modes", {30'h0, eoi_split, bp_common}, 32'h0);
        access(1'b0, 2'd1, 32'h0);
        check("R11 bp0", acc_rdata, 32'h2);

        // R1: reset mid-run
        access(1'b1, 2'd0, 32'h3);
        @(negedge clk);
        acc_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 modes", {30'h0, eoi_split, bp_common}, 32'h0);
        check("R1 rdata", acc_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, 2'd1, 32'h0);
        check("R1 bp0", acc_rdata, 32'h0);
        access(1'b0, 2'd2, 32'h0);
        check("R1 bp1", acc_rdata, 32'h0);
        idle();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule